// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block sequences a successive-approximation ADC that, once armed, converts one selected channel over and over, starting on an external hardware trigger. Software programs it through two write strobes. One loads a control word that holds an enable bit and a start bit. The other loads a channel-select field. The block drives the comparator's trial code and a sample strobe, and reads back one comparator decision per bit cycle. It then publishes each finished 10-bit code in a result register, together with a single-cycle end-of-conversion interrupt.

The sequencer has four conditions:

- **off:** the enable bit is clear.
- **standby:** enabled, with the start bit clear.
- **armed:** the start bit is set, waiting for a trigger.
- **converting.**

A conversion is one sample cycle followed by one trial per bit, MSB first. As soon as one conversion finishes, the next begins. Three events abandon the partial code and restart from the sample cycle: a trigger, any channel write, or a control write with start still set. Clearing start drops back to standby with the converter still powered. Clearing enable turns it off.

The result has no valid/ready hand-off and no back-pressure. It is a plain register that holds until the next completed conversion overwrites it. The interrupt marks the cycle in which a new value appears.

Top module: `adc_trig_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes off: result is 0, and eoc_irq, sar_busy and sar_pwr are 0.
- R2: A control write sets sar_pwr to the written enable bit. A start bit written while enable is 0 is not kept, so a later trigger starts nothing. A write with enable 0 turns the block off from any condition.
- R3: With the start bit clear, hw_trig is ignored: sar_busy and eoc_irq stay 0.
- R4: Writing enable=1, start=1 arms the block without converting: sar_busy stays 0 and no eoc_irq occurs until a trigger.
- R5: A trigger on an armed block starts a conversion on the channel in chan_sel.
  - sar_busy and sar_sample are 1 in the cycle after the trigger edge.
  - During each bit cycle, sar_dac is the trial code. cmp_in=1 means the input is at or above sar_dac, and keeps the trial bit.
  - Eleven edges after the trigger edge, result holds the code and eoc_irq is 1 for exactly one cycle.
- R6: Conversions continue back to back without a new trigger. A new eoc_irq follows every 11 cycles.
- R7: A trigger during a conversion restarts it. The next eoc_irq comes 11 edges after that trigger, and result does not change in between.
- R8: A channel write during a conversion restarts it, even when the value written is unchanged. The next result, 11 edges later, comes from the new channel.
- R9: A control write of enable=1, start=1 during a conversion restarts it. The next eoc_irq comes 11 edges later.
- R10: A control write of enable=1, start=0 during a conversion aborts it. sar_busy drops, sar_pwr stays 1, no eoc_irq follows, and result is unchanged.
- R11: A register write in the same cycle as a trigger takes priority.
  - A channel write together with a trigger converts the new channel.
  - A start-clearing control write together with a trigger ends in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctrl | input | 1 | Strobe: load the control word |
| wr_enable | input | 1 | Enable bit of the control word |
| wr_start | input | 1 | Start bit of the control word |
| wr_chan | input | 1 | Strobe: load the channel field |
| wr_chan_val | input | CH_BITS | Channel value written |
| hw_trig | input | 1 | Hardware trigger, sampled each edge |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above sar_dac |
| chan_sel | output | CH_BITS | Selected analog channel |
| sar_pwr | output | 1 | Converter powered (enable bit) |
| sar_busy | output | 1 | Conversion in progress |
| sar_sample | output | 1 | Sample cycle of a conversion |
| sar_dac | output | RES_BITS | Trial code to the comparator DAC |
| result | output | RES_BITS | Last completed conversion code |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong condition register shows within one cycle on sar_busy or sar_pwr. An off or standby block that starts converting raises sar_busy right after the stray trigger. A lost restart shows as an eoc_irq too early: fewer than 11 cycles after the restarting event, or 11 after the earlier start. A wrong bit decision or a stale channel shows in the result value at that same eoc_irq. A missed abort shows as an eoc_irq while the block should be idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_STOP  = 2'd0,
    SQ_IDLE  = 2'd1,
    SQ_ARMED = 2'd2,
    SQ_CONV  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int CH_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_enable,
  input  logic               wr_start,
  input  logic               wr_chan,
  input  logic [CH_BITS-1:0] wr_chan_val,
  output logic               en_q,
  output logic               start_q,
  output logic [CH_BITS-1:0] chan_q,
  output logic               nxt_en,
  output logic               nxt_start
);
  // A start bit is only kept while the converter is enabled.
  always_comb begin
    nxt_en    = wr_ctrl ? wr_enable : en_q;
    nxt_start = wr_ctrl ? (wr_start & wr_enable) : start_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      en_q    <= nxt_en;
      start_q <= nxt_start;
      if (wr_chan) chan_q <= wr_chan_val;
    end
  end

  AST_CHAN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chan |=> chan_q == $past(wr_chan_val)) else $error("chan load"); // R8
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_enable,
  input  logic       wr_start,
  input  logic       wr_chan,
  input  logic       hw_trig,
  input  logic       start_q,
  input  logic       nxt_en,
  input  logic       nxt_start,
  output seq_state_e state_q,
  output logic       conv_go,
  output logic       conv_abort
);
  seq_state_e state_d;
  logic       trig_ok;

  // Register writes settle the next condition first; a trigger only counts
  // when the start bit already held 1 and the write keeps it set.
  always_comb begin
    trig_ok = hw_trig & start_q;
    conv_go = 1'b0;
    if (!nxt_en) begin
      state_d = SQ_STOP;
    end else if (!nxt_start) begin
      state_d = SQ_IDLE;
    end else if (state_q == SQ_CONV) begin
      state_d = SQ_CONV;
      conv_go = trig_ok | wr_chan | wr_ctrl;
    end else if (trig_ok) begin
      state_d = SQ_CONV;
      conv_go = 1'b1;
    end else begin
      state_d = SQ_ARMED;
    end
    conv_abort = (state_q == SQ_CONV) && (state_d != SQ_CONV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_STOP;
    else        state_q <= state_d;
  end

  AST_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_enable) |=> state_q == SQ_STOP) else $error("disable"); // R2
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {SQ_STOP, SQ_IDLE}) && !wr_ctrl) |=> state_q != SQ_CONV) else $error("trig"); // R3
  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ARMED && !hw_trig && !wr_ctrl) |=> state_q == SQ_ARMED) else $error("armed"); // R4
  AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CONV && wr_ctrl && wr_enable && !wr_start) |=> state_q == SQ_IDLE) else $error("clear"); // R10
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                go,
  input  logic                abort,
  input  logic                cmp_in,
  output logic                sample,
  output logic [RES_BITS-1:0] dac,
  output logic [RES_BITS-1:0] result_q,
  output logic                eoc_q
);
  localparam int CW = $clog2(RES_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(RES_BITS);
  localparam logic [RES_BITS-1:0] MSB = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [CW-1:0]       cnt_q;
  logic [RES_BITS-1:0] trial_q, mask_q, trial_nx;

  // Keep the trial bit when the input is at or above the trial code, then
  // set the next lower bit for the following trial.
  always_comb begin
    trial_nx = (cmp_in ? trial_q : (trial_q & ~mask_q)) | (mask_q >> 1);
  end

  assign sample = run && (cnt_q == '0);
  assign dac    = trial_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      trial_q  <= '0;
      mask_q   <= '0;
      result_q <= '0;
      eoc_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (go || abort || !run) begin
        cnt_q   <= '0;
        trial_q <= '0;
        mask_q  <= '0;
      end else if (cnt_q == '0) begin
        cnt_q   <= 1'b1;
        trial_q <= MSB;
        mask_q  <= MSB;
      end else begin
        trial_q <= trial_nx;
        mask_q  <= mask_q >> 1;
        if (cnt_q == LAST) begin
          result_q <= trial_nx;
          eoc_q    <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |=> !eoc_q) else $error("eoc width"); // R5
  AST_SAMPLE_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> sample) else $error("restart"); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_q |-> $stable(result_q)) else $error("result moved"); // R7
  AST_EOC_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |-> run) else $error("eoc outside conversion"); // R10
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_BITS  = 3,
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                wr_enable,
  input  logic                wr_start,
  input  logic                wr_chan,
  input  logic [CH_BITS-1:0]  wr_chan_val,
  input  logic                hw_trig,
  input  logic                cmp_in,
  output logic [CH_BITS-1:0]  chan_sel,
  output logic                sar_pwr,
  output logic                sar_busy,
  output logic                sar_sample,
  output logic [RES_BITS-1:0] sar_dac,
  output logic [RES_BITS-1:0] result,
  output logic                eoc_irq
);
  logic       en_q, start_q, nxt_en, nxt_start, conv_go, conv_abort;
  seq_state_e state_q;

  adc_seq_regs #(.CH_BITS(CH_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_enable(wr_enable),
    .wr_start(wr_start), .wr_chan(wr_chan), .wr_chan_val(wr_chan_val),
    .en_q(en_q), .start_q(start_q), .chan_q(chan_sel),
    .nxt_en(nxt_en), .nxt_start(nxt_start)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_enable(wr_enable),
    .wr_start(wr_start), .wr_chan(wr_chan), .hw_trig(hw_trig),
    .start_q(start_q), .nxt_en(nxt_en), .nxt_start(nxt_start),
    .state_q(state_q), .conv_go(conv_go), .conv_abort(conv_abort)
  );

  assign sar_pwr  = en_q;
  assign sar_busy = (state_q == SQ_CONV);

  adc_sar_core #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .run(sar_busy), .go(conv_go),
    .abort(conv_abort), .cmp_in(cmp_in), .sample(sar_sample),
    .dac(sar_dac), .result_q(result), .eoc_q(eoc_irq)
  );

  AST_BUSY_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    sar_busy |-> sar_pwr) else $error("busy while off"); // R2
endmodule

// File: tb/adc_trig_seq_bench.sv
module adc_trig_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctrl = 1'b0, wr_enable = 1'b0, wr_start = 1'b0;
  logic       wr_chan = 1'b0;
  logic [2:0] wr_chan_val = '0;
  logic       hw_trig = 1'b0;
  logic       cmp_in;
  logic [2:0] chan_sel;
  logic       sar_pwr, sar_busy, sar_sample, eoc_irq;
  logic [9:0] sar_dac, result;
  logic [9:0] vin [0:7];

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= sar_dac);

  adc_trig_seq u_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_enable(wr_enable),
    .wr_start(wr_start), .wr_chan(wr_chan), .wr_chan_val(wr_chan_val),
    .hw_trig(hw_trig), .cmp_in(cmp_in), .chan_sel(chan_sel),
    .sar_pwr(sar_pwr), .sar_busy(sar_busy), .sar_sample(sar_sample),
    .sar_dac(sar_dac), .result(result), .eoc_irq(eoc_irq)
  );

  function automatic int sar_expect(input int v);
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic e, input logic s);
    wr_ctrl = 1'b1; wr_enable = e; wr_start = s;
    @(negedge clk);
    wr_ctrl = 1'b0;
  endtask

  task automatic wr_ch(input logic [2:0] c);
    wr_chan = 1'b1; wr_chan_val = c;
    @(negedge clk);
    wr_chan = 1'b0;
  endtask

  task automatic trig();
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
  endtask

  // Edges from the last driven edge until eoc_irq is seen (30 = timeout).
  task automatic wait_eoc(output int n);
    n = 0;
    while (!eoc_irq && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input int cyc, output int eocs, output int busy_seen);
    eocs = 0; busy_seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (eoc_irq) eocs++;
      if (sar_busy) busy_seen++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, e, b, c, d, held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) vin[i] = 10'(i * 97);
    vin[0] = 10'd677; vin[3] = 10'd1023; vin[5] = 10'd0;
    step(3);
    check("R1 result", int'(result), 0);
    check("R1 eoc", int'(eoc_irq), 0);
    check("R1 busy", int'(sar_busy), 0);
    check("R1 pwr", int'(sar_pwr), 0);
    rst_n = 1'b1;
    step(1);

    // R2: start without enable is dropped
    wr_ctl(1'b0, 1'b1);
    trig();
    quiet(15, e, b);
    check("R2 off no busy", b, 0);
    check("R2 off no eoc", e, 0);
    check("R2 off pwr", int'(sar_pwr), 0);
    wr_ctl(1'b1, 1'b0);
    check("R2 enable pwr", int'(sar_pwr), 1);
    // R3: trigger with start clear
    trig();
    quiet(15, e, b);
    check("R3 no busy", b, 0);
    check("R3 no eoc", e, 0);
    // R4: armed, waits
    wr_ch(3'd0);
    wr_ctl(1'b1, 1'b1);
    quiet(15, e, b);
    check("R4 armed no busy", b, 0);
    check("R4 armed no eoc", e, 0);
    // R5: first conversion
    trig();
    check("R5 busy", int'(sar_busy), 1);
    check("R5 sample", int'(sar_sample), 1);
    wait_eoc(n);
    check("R5 latency", n, 11);
    check("R5 result", int'(result), sar_expect(677));
    check("R5 chan", int'(chan_sel), 0);
    // R6: continuous, new value picked up by the next conversion
    vin[0] = 10'd100;
    step(1);
    check("R6 eoc one cycle", int'(eoc_irq), 0);
    wait_eoc(n);
    check("R6 period", n + 1, 11);
    check("R6 result", int'(result), 100);
    // R7: trigger mid conversion restarts
    vin[0] = 10'd555;
    step(4);
    held = int'(result);
    trig();
    wait_eoc(n);
    check("R7 restart latency", n, 11);
    step(0);
    check("R7 result", int'(result), 555);
    check("R7 held before", held, 100);
    // R8: same-value channel write restarts
    step(5);
    wr_ch(3'd0);
    wait_eoc(n);
    check("R8 same chan latency", n, 11);
    step(3);
    wr_ch(3'd3);
    wait_eoc(n);
    check("R8 new chan latency", n, 11);
    check("R8 new chan result", int'(result), 1023);
    check("R8 chan_sel", int'(chan_sel), 3);
    // R9: start rewrite restarts
    step(6);
    wr_ctl(1'b1, 1'b1);
    wait_eoc(n);
    check("R9 latency", n, 11);
    // R10: start clear aborts
    step(7);
    held = int'(result);
    wr_ctl(1'b1, 1'b0);
    check("R10 busy", int'(sar_busy), 0);
    check("R10 pwr", int'(sar_pwr), 1);
    quiet(20, e, b);
    check("R10 no eoc", e, 0);
    check("R10 result held", int'(result), held);
    // R11: channel write with trigger converts new channel
    wr_ctl(1'b1, 1'b1);
    trig();
    step(3);
    wr_chan = 1'b1; wr_chan_val = 3'd5; hw_trig = 1'b1;
    @(negedge clk);
    wr_chan = 1'b0; hw_trig = 1'b0;
    wait_eoc(n);
    check("R11 chan+trig latency", n, 11);
    check("R11 chan+trig result", int'(result), 0);
    // R11: start-clear with trigger ends in standby
    step(4);
    wr_ctrl = 1'b1; wr_enable = 1'b1; wr_start = 1'b0; hw_trig = 1'b1;
    @(negedge clk);
    wr_ctrl = 1'b0; hw_trig = 1'b0;
    quiet(15, e, b);
    check("R11 clear+trig busy", b, 0);
    check("R11 clear+trig eoc", e, 0);
    // R2: disable turns off
    wr_ctl(1'b0, 1'b0);
    check("R2 disable pwr", int'(sar_pwr), 0);

    // Random: channel writes, triggers, aborts (R5, R7, R8)
    wr_ctl(1'b1, 1'b1);
    for (int k = 0; k < 40; k++) begin
      c = int'($urandom % 8);
      vin[c] = 10'($urandom % 1024);
      wr_ch(3'(c));
      trig();
      d = int'($urandom % 14);
      if (d < 10) begin
        step(d);
        trig();
      end
      wait_eoc(n);
      check("R7 random latency", n, 11);
      check("R5 random result", int'(result), sar_expect(int'(vin[c])));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule